// File: doc/BRIEF.md
# Per-Processor GPIO Interrupt Mask Bank

This block is the interrupt qualification stage of one 32-line GPIO bank that serves several processors. It receives the already polarity-corrected input levels and a one-cycle pulse for every detected edge. It holds edge-cause and mask state in registers. For every processor it produces a set of group interrupt requests. Each processor has its own edge mask and its own level mask, so a single line can be routed to one processor, to several, or to none.

A parameter selects between two register layouts. In the dual-processor layout, both processors share one edge cause register. Their masks sit at fixed offsets in the main register window. In the quad-processor layout, the main window holds a shared cause register and shared masks, which drive a separate global request output. A second window then holds a private cause register, an edge mask and a level mask for each of the four processors. All of these are at strided offsets.

Registers are accessed through a simple write strobe and a combinational read port. A one-bit window select picks either the main window or the per-processor window.

Top module: `gpio_pcpu_irq_bank`

## Requirements
- R1: While reset is applied, and right after it, every cause and mask register reads 0, and every request output is 0, whatever the inputs.
- R2: Processor c requests line i when level_in[i] is 1 and bit i of that processor's level mask is 1.
- R3: A 1 on edge_evt[i] at a clock edge sets bit i of every edge cause register. A processor requests line i when the bit is set in the cause register it uses and bit i of its edge mask is 1.
- R4: Writing a cause register clears each bit written as 0 and keeps each bit written as 1. When an edge arrives in the same cycle as a clearing write, the bit ends up set. Without a write, set bits stay set.
- R5: In the dual-processor layout (NUM_CPU=2), the main window (win_sel=0) decodes the following offsets. Shared cause is at 0x14. Processor 0 has its edge mask at 0x18 and its level mask at 0x1C. Processor 1 has its edge mask at 0x30 and its level mask at 0x34. Both processors qualify edges from the shared cause.
- R6: In the quad-processor layout (NUM_CPU=4), the per-processor window (win_sel=1) decodes the following offsets. Processor c has its cause at c*4, its edge mask at 0x10+c*4 and its level mask at 0x20+c*4. Each processor qualifies edges from its own cause register.
- R7: In the quad-processor layout, an edge sets the bit in all four private cause registers. A processor clearing its own copy leaves the other copies untouched.
- R8: In the quad-processor layout, the main window holds a global cause at 0x14, a global edge mask at 0x18 and a global level mask at 0x1C. These drive glob_irq with the same request rule. In the dual-processor layout, glob_irq stays 0.
- R9: Request line i of processor c drives cpu_irq[c*4 + i/8]. That output is the OR of lines 8g to 8g+7.
- R10: Reads of an offset that the selected layout and window do not decode return 0. Writes to such an offset change no register and no output.
- R11: Mask settings of one processor have no effect on the requests of any other processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| win_sel | input | 1 | Window select: 0 main window, 1 per-processor window |
| addr | input | 8 | Byte offset within the selected window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for win_sel/addr, combinational |
| level_in | input | 32 | Polarity-corrected input levels |
| edge_evt | input | 32 | One-cycle pulses of detected edges |
| cpu_irq | output | NUM_CPU*4 | Group requests, four per processor, processor c at bits c*4+3..c*4 |
| glob_irq | output | 4 | Group requests from the global registers (quad layout only) |

## Verification
Two instances are tested, one in each layout. The level tests use bit patterns on either side of a group boundary, such as lines 7, 8 and 31. These patterns show whether each line lands in the right summary output and the right processor. The edge tests pulse one line per group and then clear the cause bits through different processors. This separates a shared cause register from private copies. A clearing write that coincides with a new edge shows whether set or clear takes priority. Writes to offsets that are unmapped in only one of the two layouts, with all inputs at one, show that the decode follows the layout.

// File: rtl/gpio_pcpu_pkg.sv
package gpio_pcpu_pkg;

  localparam logic WIN_MAIN = 1'b0;
  localparam logic WIN_CPU  = 1'b1;

  localparam logic [7:0] OFF_GCAUSE = 8'h14;
  localparam logic [7:0] OFF_GEMASK = 8'h18;
  localparam logic [7:0] OFF_GLMASK = 8'h1C;

  // dual-processor layout, main window
  function automatic logic [7:0] duo_emask_off(input int c);
    return (c != 0) ? 8'h30 : 8'h18;
  endfunction

  function automatic logic [7:0] duo_lmask_off(input int c);
    return (c != 0) ? 8'h34 : 8'h1C;
  endfunction

  // quad-processor layout, per-processor window
  function automatic logic [7:0] quad_cause_off(input int c);
    return 8'(c * 4);
  endfunction

  function automatic logic [7:0] quad_emask_off(input int c);
    return 8'(16 + c * 4);
  endfunction

  function automatic logic [7:0] quad_lmask_off(input int c);
    return 8'(32 + c * 4);
  endfunction

endpackage

// File: rtl/gpio_pcpu_mask_reg.sv
module gpio_pcpu_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/gpio_pcpu_cause_reg.sv
module gpio_pcpu_cause_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] evt,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  // a zero written clears, a one keeps; a new event always wins
  always_comb begin
    q_nxt = q;
    if (we) q_nxt = q_nxt & wdata;
    q_nxt = q_nxt | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/gpio_pcpu_grp_or.sv
module gpio_pcpu_grp_or #(
  parameter int W   = 32,
  parameter int GRP = 8
) (
  input  logic [W-1:0]     vec,
  output logic [W/GRP-1:0] grp
);

  localparam int NG = W / GRP;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp[g] = |vec[g*GRP +: GRP];
  end

endmodule

// File: rtl/gpio_pcpu_irq_bank.sv
module gpio_pcpu_irq_bank
  import gpio_pcpu_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int LINES   = 32,
  parameter int GRP     = 8,
  parameter int ADDR_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     win_sel,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LINES-1:0]         wdata,
  output logic [LINES-1:0]         rdata,
  input  logic [LINES-1:0]         level_in,
  input  logic [LINES-1:0]         edge_evt,
  output logic [NUM_CPU*(LINES/GRP)-1:0] cpu_irq,
  output logic [LINES/GRP-1:0]     glob_irq
);

  localparam int NGRP = LINES / GRP;
  localparam bit QUAD = (NUM_CPU == 4);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i = rst_q[1];

  logic in_main, in_cpu;
  assign in_main = (win_sel == WIN_MAIN);
  assign in_cpu  = (win_sel == WIN_CPU);

  // shared cause, present in both layouts
  logic [LINES-1:0] gcause;
  logic             gcause_we;
  assign gcause_we = wr_en && in_main && (addr == ADDR_W'(OFF_GCAUSE));

  gpio_pcpu_cause_reg #(.W(LINES)) u_gcause (
    .clk(clk), .rst_n(rst_i), .we(gcause_we), .wdata(wdata),
    .evt(edge_evt), .q(gcause)
  );

  logic [LINES-1:0] em_q [NUM_CPU];
  logic [LINES-1:0] lm_q [NUM_CPU];
  logic [LINES-1:0] pc_q [NUM_CPU];
  logic [NUM_CPU-1:0] em_we, lm_we, pc_we;
  logic [LINES-1:0] gem, glm;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [LINES-1:0] src_cause;
    logic [LINES-1:0] req;

    if (QUAD) begin : g_quad
      assign em_we[c] = wr_en && in_cpu && (addr == ADDR_W'(quad_emask_off(c)));
      assign lm_we[c] = wr_en && in_cpu && (addr == ADDR_W'(quad_lmask_off(c)));
      assign pc_we[c] = wr_en && in_cpu && (addr == ADDR_W'(quad_cause_off(c)));

      gpio_pcpu_cause_reg #(.W(LINES)) u_pcause (
        .clk(clk), .rst_n(rst_i), .we(pc_we[c]), .wdata(wdata),
        .evt(edge_evt), .q(pc_q[c])
      );
      assign src_cause = pc_q[c];
    end else begin : g_duo
      assign em_we[c] = wr_en && in_main && (addr == ADDR_W'(duo_emask_off(c)));
      assign lm_we[c] = wr_en && in_main && (addr == ADDR_W'(duo_lmask_off(c)));
      assign pc_we[c] = 1'b0;
      assign pc_q[c]  = '0;
      assign src_cause = gcause;
    end

    gpio_pcpu_mask_reg #(.W(LINES)) u_emask (
      .clk(clk), .rst_n(rst_i), .we(em_we[c]), .wdata(wdata), .q(em_q[c])
    );
    gpio_pcpu_mask_reg #(.W(LINES)) u_lmask (
      .clk(clk), .rst_n(rst_i), .we(lm_we[c]), .wdata(wdata), .q(lm_q[c])
    );

    assign req = (level_in & lm_q[c]) | (src_cause & em_q[c]);

    gpio_pcpu_grp_or #(.W(LINES), .GRP(GRP)) u_grp (
      .vec(req), .grp(cpu_irq[c*NGRP +: NGRP])
    );
  end

  if (QUAD) begin : g_glob
    logic gem_we, glm_we;
    logic [LINES-1:0] greq;
    assign gem_we = wr_en && in_main && (addr == ADDR_W'(OFF_GEMASK));
    assign glm_we = wr_en && in_main && (addr == ADDR_W'(OFF_GLMASK));

    gpio_pcpu_mask_reg #(.W(LINES)) u_gemask (
      .clk(clk), .rst_n(rst_i), .we(gem_we), .wdata(wdata), .q(gem)
    );
    gpio_pcpu_mask_reg #(.W(LINES)) u_glmask (
      .clk(clk), .rst_n(rst_i), .we(glm_we), .wdata(wdata), .q(glm)
    );

    assign greq = (level_in & glm) | (gcause & gem);

    gpio_pcpu_grp_or #(.W(LINES), .GRP(GRP)) u_ggrp (
      .vec(greq), .grp(glob_irq)
    );
  end else begin : g_noglob
    assign gem      = '0;
    assign glm      = '0;
    assign glob_irq = '0;
  end

  // read decode
  logic rd_hit;

  always_comb begin
    rdata  = '0;
    rd_hit = 1'b0;
    if (in_main && addr == ADDR_W'(OFF_GCAUSE)) begin
      rdata = gcause; rd_hit = 1'b1;
    end
    if (QUAD) begin
      if (in_main && addr == ADDR_W'(OFF_GEMASK)) begin
        rdata = gem; rd_hit = 1'b1;
      end
      if (in_main && addr == ADDR_W'(OFF_GLMASK)) begin
        rdata = glm; rd_hit = 1'b1;
      end
      for (int c = 0; c < NUM_CPU; c++) begin
        if (in_cpu && addr == ADDR_W'(quad_cause_off(c))) begin
          rdata = pc_q[c]; rd_hit = 1'b1;
        end
        if (in_cpu && addr == ADDR_W'(quad_emask_off(c))) begin
          rdata = em_q[c]; rd_hit = 1'b1;
        end
        if (in_cpu && addr == ADDR_W'(quad_lmask_off(c))) begin
          rdata = lm_q[c]; rd_hit = 1'b1;
        end
      end
    end else begin
      for (int c = 0; c < NUM_CPU; c++) begin
        if (in_main && addr == ADDR_W'(duo_emask_off(c))) begin
          rdata = em_q[c]; rd_hit = 1'b1;
        end
        if (in_main && addr == ADDR_W'(duo_lmask_off(c))) begin
          rdata = lm_q[c]; rd_hit = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/gpio_pcpu_irq_bank_chk.sv
module gpio_pcpu_irq_bank_chk #(
  parameter int NUM_CPU = 4,
  parameter int LINES   = 32,
  parameter int NGRP    = 4
) (
  input logic                      clk,
  input logic                      rst_i,
  input logic [LINES-1:0]          edge_evt,
  input logic [LINES-1:0]          gcause,
  input logic                      gcause_we,
  input logic [LINES-1:0]          pc_q [NUM_CPU],
  input logic [NUM_CPU-1:0]        pc_we,
  input logic [LINES-1:0]          em_q [NUM_CPU],
  input logic [LINES-1:0]          lm_q [NUM_CPU],
  input logic [NUM_CPU*NGRP-1:0]   cpu_irq,
  input logic [NGRP-1:0]           glob_irq,
  input logic                      rd_hit,
  input logic [LINES-1:0]          rdata
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_i |-> (cpu_irq == '0 && glob_irq == '0));

  assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rst_i)
    1'b1 |=> ((gcause & $past(edge_evt)) == $past(edge_evt)));

  assert_cause_hold_R4: assert property (@(posedge clk) disable iff (!rst_i)
    !gcause_we |=> (($past(gcause) & ~gcause) == '0));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_i)
    !rd_hit |-> rdata == '0);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    assert_masked_silent_R11: assert property (@(posedge clk) disable iff (!rst_i)
      (em_q[c] == '0 && lm_q[c] == '0) |-> cpu_irq[c*NGRP +: NGRP] == '0);

    if (NUM_CPU == 4) begin : g_q
      assert_pcpu_sets_R7: assert property (@(posedge clk) disable iff (!rst_i)
        1'b1 |=> ((pc_q[c] & $past(edge_evt)) == $past(edge_evt)));

      assert_pcpu_hold_R4: assert property (@(posedge clk) disable iff (!rst_i)
        !pc_we[c] |=> (($past(pc_q[c]) & ~pc_q[c]) == '0));
    end
  end

endmodule

bind gpio_pcpu_irq_bank gpio_pcpu_irq_bank_chk #(
  .NUM_CPU(NUM_CPU), .LINES(LINES), .NGRP(NGRP)
) chk_i (
  .clk(clk), .rst_i(rst_i), .edge_evt(edge_evt), .gcause(gcause),
  .gcause_we(gcause_we), .pc_q(pc_q), .pc_we(pc_we), .em_q(em_q),
  .lm_q(lm_q), .cpu_irq(cpu_irq), .glob_irq(glob_irq), .rd_hit(rd_hit),
  .rdata(rdata)
);

// File: tb/gpio_pcpu_irq_bank_tb_top.sv
module gpio_pcpu_irq_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_a = 1'b0, wr_b = 1'b0;
  logic        win_sel = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] level_in = '0;
  logic [31:0] edge_evt = '0;
  logic [31:0] rdata_a, rdata_b;
  logic [15:0] irq_a;
  logic [7:0]  irq_b;
  logic [3:0]  girq_a, girq_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_pcpu_irq_bank #(.NUM_CPU(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_a), .win_sel(win_sel), .addr(addr),
    .wdata(wdata), .rdata(rdata_a), .level_in(level_in), .edge_evt(edge_evt),
    .cpu_irq(irq_a), .glob_irq(girq_a)
  );

  gpio_pcpu_irq_bank #(.NUM_CPU(2)) dut2_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_b), .win_sel(win_sel), .addr(addr),
    .wdata(wdata), .rdata(rdata_b), .level_in(level_in), .edge_evt(edge_evt),
    .cpu_irq(irq_b), .glob_irq(girq_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_a = 0; wr_b = 0; level_in = '0; edge_evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // quad: 1 selects dut_i, 0 selects dut2_i
  task automatic wr(input bit quad, input logic win, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_a = quad; wr_b = !quad; win_sel = win; addr = a; wdata = d;
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0;
  endtask

  task automatic rd(input bit quad, input logic win, input logic [7:0] a,
                    input logic [31:0] exp, input string tag);
    win_sel = win; addr = a;
    #1;
    chk(tag, quad ? rdata_a : rdata_b, exp);
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk); edge_evt = v;
    @(negedge clk); edge_evt = '0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; level_in = '1; edge_evt = '1;
    repeat (2) @(negedge clk);
    chk("R1 quad irq in reset", {16'h0, irq_a}, 32'h0);
    chk("R1 duo irq in reset", {24'h0, irq_b}, 32'h0);
    edge_evt = '0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 quad irq after reset", {12'h0, girq_a, irq_a}, 32'h0);
    rd(1, 1'b0, 8'h14, 32'h0, "R1 quad global cause");
    rd(1, 1'b1, 8'h0C, 32'h0, "R1 quad cpu3 cause");
    rd(0, 1'b0, 8'h34, 32'h0, "R1 duo cpu1 level mask");
    level_in = '0;
  endtask

  task automatic t_duo_level();
    do_reset();
    wr(0, 1'b0, 8'h1C, 32'h0000_0180);
    wr(0, 1'b0, 8'h34, 32'h8000_0000);
    rd(0, 1'b0, 8'h1C, 32'h0000_0180, "R5 duo cpu0 lmask readback");
    rd(0, 1'b0, 8'h34, 32'h8000_0000, "R5 duo cpu1 lmask readback");
    rd(0, 1'b0, 8'h18, 32'h0, "R5 duo cpu0 emask untouched");
    level_in = 32'h0000_0080; #1;
    chk("R9 line7 to group0", {24'h0, irq_b}, 32'h01);
    level_in = 32'h0000_0100; #1;
    chk("R9 line8 to group1", {24'h0, irq_b}, 32'h02);
    level_in = 32'h8000_0100; #1;
    chk("R2 two cpus level", {24'h0, irq_b}, 32'h82);
    level_in = 32'h8000_0000; #1;
    chk("R11 cpu1 only", {24'h0, irq_b}, 32'h80);
    level_in = '0; #1;
    chk("R2 level low", {24'h0, irq_b}, 32'h0);
  endtask

  task automatic t_duo_edge();
    do_reset();
    wr(0, 1'b0, 8'h18, 32'h0000_0001);
    wr(0, 1'b0, 8'h30, 32'h0001_0000);
    pulse(32'h0001_0001);
    chk("R3 duo edge requests", {24'h0, irq_b}, 32'h41);
    rd(0, 1'b0, 8'h14, 32'h0001_0001, "R5 duo shared cause");
    repeat (2) @(negedge clk);
    chk("R4 cause held", {24'h0, irq_b}, 32'h41);
    wr(0, 1'b0, 8'h14, 32'hFFFF_FFFE);
    rd(0, 1'b0, 8'h14, 32'h0001_0000, "R4 write0 clears write1 keeps");
    chk("R4 irq after clear", {24'h0, irq_b}, 32'h40);
    @(negedge clk);
    wr_b = 1'b1; win_sel = 1'b0; addr = 8'h14; wdata = 32'h0; edge_evt = 32'h1;
    @(negedge clk);
    wr_b = 1'b0; edge_evt = '0;
    rd(0, 1'b0, 8'h14, 32'h0000_0001, "R4 edge beats clear");
    chk("R4 irq edge beats clear", {24'h0, irq_b}, 32'h01);
  endtask

  task automatic t_quad_percpu();
    do_reset();
    for (int c = 0; c < 4; c++) wr(1, 1'b1, 8'(16 + c*4), 32'h1 << (c*8));
    pulse(32'h0101_0101);
    chk("R6 quad per-cpu edge", {16'h0, irq_a}, 32'h8421);
    for (int c = 0; c < 4; c++) rd(1, 1'b1, 8'(c*4), 32'h0101_0101, "R7 every copy set");
    wr(1, 1'b1, 8'h04, 32'h0);
    rd(1, 1'b1, 8'h04, 32'h0, "R7 cpu1 copy cleared");
    rd(1, 1'b1, 8'h00, 32'h0101_0101, "R7 cpu0 copy kept");
    rd(1, 1'b1, 8'h08, 32'h0101_0101, "R7 cpu2 copy kept");
    chk("R7 irq after cpu1 clear", {16'h0, irq_a}, 32'h8401);
    wr(1, 1'b1, 8'h28, 32'h2);
    rd(1, 1'b1, 8'h28, 32'h2, "R6 cpu2 lmask readback");
    level_in = 32'h2; #1;
    chk("R6 cpu2 level", {16'h0, irq_a}, 32'h8501);
    level_in = '0;
  endtask

  task automatic t_quad_global();
    do_reset();
    wr(1, 1'b0, 8'h1C, 32'h0100_0000);
    level_in = 32'h0100_0000; #1;
    chk("R8 global level", {28'h0, girq_a}, 32'h8);
    chk("R11 per-cpu quiet", {16'h0, irq_a}, 32'h0);
    wr(1, 1'b0, 8'h18, 32'h10);
    pulse(32'h10);
    chk("R8 global edge", {28'h0, girq_a}, 32'h9);
    rd(1, 1'b0, 8'h14, 32'h10, "R8 global cause");
    chk("R8 duo glob_irq zero", {28'h0, girq_b}, 32'h0);
    level_in = '0;
  endtask

  task automatic t_unmapped();
    do_reset();
    wr(1, 1'b0, 8'h30, 32'hFFFF_FFFF);
    wr(1, 1'b1, 8'h30, 32'hFFFF_FFFF);
    wr(0, 1'b1, 8'h10, 32'hFFFF_FFFF);
    wr(0, 1'b1, 8'h20, 32'hFFFF_FFFF);
    rd(1, 1'b0, 8'h30, 32'h0, "R10 quad main 0x30 reads 0");
    rd(1, 1'b1, 8'h30, 32'h0, "R10 quad cpu window 0x30 reads 0");
    rd(0, 1'b1, 8'h10, 32'h0, "R10 duo cpu window reads 0");
    rd(1, 1'b1, 8'h20, 32'h0, "R10 quad cpu0 lmask untouched");
    level_in = '1; #1;
    chk("R10 quad irq stays 0", {12'h0, girq_a, irq_a}, 32'h0);
    chk("R10 duo irq stays 0", {24'h0, irq_b}, 32'h0);
    level_in = '0;
  endtask

  initial begin
    t_reset();
    t_duo_level();
    t_duo_edge();
    t_quad_percpu();
    t_quad_global();
    t_unmapped();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule